// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of 32. Each per-pin feature (direction, output value, interrupt enable, sensitivity type, polarity and pending status) has one 32-bit word per bank. A word is reached through a simple single-cycle register bus. The controller drives a pad output-enable vector and a pad output vector. It samples the pad input vector through a two-flop synchroniser.

Each pin can raise an interrupt on a high level, a low level, a rising edge or a falling edge. The pending status is latched per pin, and software clears it by writing a 1 to the bit. There are several interrupt-enable sets. Only set 0 gates the single combined interrupt output; the other sets can be read and written but drive nothing in this block.

With the default parameters the controller has 70 pins in three banks. Bit positions above the last pin read as zero and ignore writes.

Top module: `bgpio_ctrl`

## Requirements
- R1: Pin n sits at bit n%32 of the word at feature base + (n/32)*4. The bases are: direction 0x14, pad data 0x24, polarity 0x104, type 0x114, status 0x124, and enable set k at 0x44 + 0x10*k for k = 0..3. A read returns the addressed word in `bus_rdata` one cycle after the request.
- R2: Reset clears direction, output data, polarity, type, all enable sets and all status bits. After reset `pad_oe` and `irq_out` are 0.
- R3: `pad_oe` bit n is 1 exactly when direction bit n is 1 (1 = output, 0 = input). `pad_out` carries the written data bits. Both change only in the cycle after a bus write.
- R4: A read of pad data returns the driven value for output pins and the synchronised `pad_in` value for input pins.
- R5: With type 0 (level) and polarity 0 (high), a high input sets the status bit. If the level persists, the bit sets again after it is cleared.
- R6: With type 0 and polarity 1 (low), a low input sets the status bit.
- R7: With type 1 (edge) and polarity 0, a rising input sets the status bit once. After it is cleared, the bit stays clear while the input stays high.
- R8: With type 1 and polarity 1, a falling input sets the status bit, and a rising input does not.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: `irq_out` is 1 exactly when some pin has both its status bit and its set-0 enable bit at 1. The other enable sets have no effect on `irq_out`.
- R11: Bits above the last implemented pin read as 0 in every feature word, and writes to them are ignored.
- R12: Status bits latch whether or not any enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad output values |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is one where the same pin, at the same moment, both holds an active input and receives a clear. This is how a persistent level re-arms while an edge does not. The bench holds a pin's input at its active level across the clear write. It then reads status after the synchroniser delay and expects the bit to be set again for a level pin and clear for an edge pin. The bench also separates the two effects of the enable: it first latches status while the pin is masked, then enables the pin through set 1 (which must not raise `irq_out`), and only then through set 0.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;
  localparam int WORD_W     = 32;
  localparam int OFF_DIR    = 'h014;
  localparam int OFF_DATA   = 'h024;
  localparam int OFF_IE0    = 'h044;
  localparam int IE_STRIDE  = 'h010;
  localparam int OFF_POL    = 'h104;
  localparam int OFF_TYPE   = 'h114;
  localparam int OFF_STAT   = 'h124;
endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/bgpio_irq_detect.sv
module bgpio_irq_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] typ,
  input  logic [N-1:0] clr,
  output logic [N-1:0] hit,
  output logic [N-1:0] stat
);
  logic [N-1:0] prev_q;

  // Per-pin event: level (type 0) or edge (type 1); polarity 1 inverts.
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i] = typ[i] ? (pol[i] ? (prev_q[i] & ~smp[i]) : (~prev_q[i] & smp[i]))
                           : (smp[i] ^ pol[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat   <= '0;
    end else begin
      prev_q <= smp;
      stat   <= (stat & ~clr) | hit;   // a new event wins over a clear
    end
  end
endmodule

// File: rtl/bgpio_ctrl.sv
module bgpio_ctrl #(
  parameter int NUM_PINS    = 70,
  parameter int NUM_IE_SETS = 4,
  parameter int ADDR_W      = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic                irq_out
);
  import bgpio_pkg::*;

  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_BANKS * WORD_W;
  localparam int SPAN      = NUM_BANKS * 4;

  logic [NUM_PINS-1:0] dir_q, dout_q, pol_q, typ_q;
  logic [NUM_PINS-1:0] ie_q [NUM_IE_SETS];
  logic [NUM_PINS-1:0] smp, hit, stat, clr, pin_val;
  logic [31:0]         rd_word;
  logic                wr_en, rd_en;

  function automatic logic hits(input logic [ADDR_W-1:0] a, input int base);
    return (a[1:0] == 2'b00) && (int'(a) >= base) && (int'(a) < base + SPAN);
  endfunction

  function automatic int bank_of(input logic [ADDR_W-1:0] a, input int base);
    return (int'(a) - base) / 4;
  endfunction

  function automatic logic [NUM_PINS-1:0] merge(input logic [NUM_PINS-1:0] old,
                                                input int bank,
                                                input logic [31:0] w);
    logic [PAD_W-1:0] p;
    p = PAD_W'(old);
    p[bank*WORD_W +: WORD_W] = w;
    return p[NUM_PINS-1:0];
  endfunction

  function automatic logic [31:0] word_of(input logic [NUM_PINS-1:0] v, input int bank);
    logic [PAD_W-1:0] p;
    p = PAD_W'(v);
    return p[bank*WORD_W +: WORD_W];
  endfunction

  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;

  bgpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(smp)
  );

  always_comb begin
    clr = '0;
    if (wr_en && hits(bus_addr, OFF_STAT))
      clr = merge('0, bank_of(bus_addr, OFF_STAT), bus_wdata);
  end

  bgpio_irq_detect #(.N(NUM_PINS)) u_det (
    .clk(clk), .rst(rst), .smp(smp), .pol(pol_q), .typ(typ_q),
    .clr(clr), .hit(hit), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
      typ_q  <= '0;
      for (int k = 0; k < NUM_IE_SETS; k++) ie_q[k] <= '0;
    end else if (wr_en) begin
      if (hits(bus_addr, OFF_DIR))  dir_q  <= merge(dir_q,  bank_of(bus_addr, OFF_DIR),  bus_wdata);
      if (hits(bus_addr, OFF_DATA)) dout_q <= merge(dout_q, bank_of(bus_addr, OFF_DATA), bus_wdata);
      if (hits(bus_addr, OFF_POL))  pol_q  <= merge(pol_q,  bank_of(bus_addr, OFF_POL),  bus_wdata);
      if (hits(bus_addr, OFF_TYPE)) typ_q  <= merge(typ_q,  bank_of(bus_addr, OFF_TYPE), bus_wdata);
      for (int k = 0; k < NUM_IE_SETS; k++)
        if (hits(bus_addr, OFF_IE0 + k*IE_STRIDE))
          ie_q[k] <= merge(ie_q[k], bank_of(bus_addr, OFF_IE0 + k*IE_STRIDE), bus_wdata);
    end
  end

  assign pin_val = (dir_q & dout_q) | (~dir_q & smp);

  always_comb begin
    rd_word = '0;
    if (hits(bus_addr, OFF_DIR))  rd_word = word_of(dir_q,   bank_of(bus_addr, OFF_DIR));
    if (hits(bus_addr, OFF_DATA)) rd_word = word_of(pin_val, bank_of(bus_addr, OFF_DATA));
    if (hits(bus_addr, OFF_POL))  rd_word = word_of(pol_q,   bank_of(bus_addr, OFF_POL));
    if (hits(bus_addr, OFF_TYPE)) rd_word = word_of(typ_q,   bank_of(bus_addr, OFF_TYPE));
    if (hits(bus_addr, OFF_STAT)) rd_word = word_of(stat,    bank_of(bus_addr, OFF_STAT));
    for (int k = 0; k < NUM_IE_SETS; k++)
      if (hits(bus_addr, OFF_IE0 + k*IE_STRIDE))
        rd_word = word_of(ie_q[k], bank_of(bus_addr, OFF_IE0 + k*IE_STRIDE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_word;
      irq_out <= |(stat & ie_q[0]);
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = dout_q;
endmodule

// File: rtl/bgpio_checker.sv
module bgpio_checker #(
  parameter int NUM_PINS = 70,
  parameter int ADDR_W   = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] stat,
  input logic [NUM_PINS-1:0] ie0,
  input logic [NUM_PINS-1:0] hit
);
  localparam int NUM_BANKS = (NUM_PINS + 31) / 32;
  localparam int TOP_BITS  = NUM_PINS - (NUM_BANKS - 1) * 32;
  localparam logic [ADDR_W-1:0] STAT_TOP = ADDR_W'('h124 + (NUM_BANKS - 1) * 4);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && !irq_out)); // R2

  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && bus_write) |-> $stable(pad_oe)); // R3

  AST_STATUS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(stat)) != '0) |-> ($past(hit) != '0)); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past((stat & ie0) != '0)); // R10

  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write && bus_addr == STAT_TOP) |-> ((bus_rdata >> TOP_BITS) == '0)); // R11
endmodule

bind bgpio_ctrl bgpio_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_oe(pad_oe), .irq_out(irq_out),
  .stat(stat), .ie0(ie_q[0]), .hit(hit)
);

// File: tb/sim_bgpio_ctrl.sv
module sim_bgpio_ctrl;
  localparam int NP = 70;
  localparam logic [8:0] A_DIR  = 9'h014;
  localparam logic [8:0] A_DATA = 9'h024;
  localparam logic [8:0] A_IE0  = 9'h044;
  localparam logic [8:0] A_IE1  = 9'h054;
  localparam logic [8:0] A_POL  = 9'h104;
  localparam logic [8:0] A_TYPE = 9'h114;
  localparam logic [8:0] A_STAT = 9'h124;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;
  logic          irq_out;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_issued = 1'b0;

  always #5 clk = ~clk;

  bgpio_ctrl u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out)
  );

  task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // Driver: issue a read and push the expected word for the monitor.
  task automatic rd(logic [8:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare the read word one cycle after the request.
  always @(posedge clk) rd_issued <= bus_valid && !bus_write && !rst;
  always @(negedge clk) begin
    if (rd_issued) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 actual=%h expected=<none queued>", bus_rdata);
      end else begin
        check_val(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    check_val("R2 pad_oe", 32'(pad_oe), 32'h0);
    check_val("R2 irq_out", 32'(irq_out), 32'h0);
    rd(A_DIR, 32'h0, "R2 dir bank0");
    rd(A_STAT + 9'd4, 32'h0, "R2 status bank1");
    rd(A_IE0 + 9'd8, 32'h0, "R2 enable bank2");

    // R3/R4: pin 40 (bank1 bit 8) as output driven high
    wr(A_DIR + 9'd4, 32'h0000_0100);
    check_val("R3 pad_oe pin40", 32'(pad_oe[40]), 32'h1);
    wr(A_DATA + 9'd4, 32'h0000_0100);
    check_val("R3 pad_out pin40", 32'(pad_out[40]), 32'h1);
    rd(A_DATA + 9'd4, 32'h0000_0100, "R4 output readback");
    pad_in[41] = 1'b1;                      // input pin, bank1 bit 9
    idle(4);
    rd(A_DATA + 9'd4, 32'h0000_0300, "R4 input readback");
    rd(A_STAT + 9'd4, 32'h0000_0200, "R12 status unmasked-free latch");
    pad_in[41] = 1'b0;
    idle(4);
    wr(A_STAT + 9'd4, 32'hFFFF_FFFF);
    rd(A_STAT + 9'd4, 32'h0, "R9 clear bank1");

    // R1/R11: top bank only holds 6 pins
    wr(A_DIR + 9'd8, 32'hFFFF_FFFF);
    rd(A_DIR + 9'd8, 32'h0000_003F, "R11 top bits read zero");
    check_val("R1 pad_oe bank2", 32'(pad_oe[69:64]), 32'h3F);
    wr(A_DIR + 9'd8, 32'h0);
    wr(A_IE0 + 9'h30, 32'h1234_5678);       // enable set 3 bank0
    rd(A_IE0 + 9'h30, 32'h1234_5678, "R1 enable set3 addressing");
    wr(A_IE0 + 9'h30, 32'h0);

    // R5: level high, pin 3; re-sets after clear while held
    pad_in[3] = 1'b1;
    idle(4);
    rd(A_STAT, 32'h0000_0008, "R5 level high sets");
    wr(A_STAT, 32'h0000_0008);
    idle(2);
    rd(A_STAT, 32'h0000_0008, "R5 level persists re-sets");
    pad_in[3] = 1'b0;
    idle(4);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, 32'h0, "R5 cleared after release");

    // R6: level low, pin 5
    wr(A_POL, 32'h0000_0020);
    idle(2);
    rd(A_STAT, 32'h0000_0020, "R6 level low sets");
    pad_in[5] = 1'b1;
    idle(4);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, 32'h0, "R6 inactive high stays clear");

    // R7/R9: rising edge, pin 69 (bank2 bit 5)
    wr(A_TYPE + 9'd8, 32'h0000_0020);
    pad_in[69] = 1'b1;
    idle(4);
    rd(A_STAT + 9'd8, 32'h0000_0020, "R7 rising sets");
    wr(A_STAT + 9'd8, 32'h0);
    rd(A_STAT + 9'd8, 32'h0000_0020, "R9 write zero keeps");
    wr(A_STAT + 9'd8, 32'h0000_0020);
    idle(3);
    rd(A_STAT + 9'd8, 32'h0, "R7 held high no re-set");

    // R8: falling edge, pin 33 (bank1 bit 1)
    wr(A_TYPE + 9'd4, 32'h0000_0002);
    wr(A_POL + 9'd4, 32'h0000_0002);
    pad_in[33] = 1'b1;
    idle(4);
    rd(A_STAT + 9'd4, 32'h0, "R8 rising ignored");
    pad_in[33] = 1'b0;
    idle(4);
    rd(A_STAT + 9'd4, 32'h0000_0002, "R8 falling sets");

    // R10/R12: pin 3 pending while masked, then enables
    pad_in[3] = 1'b1;
    idle(4);
    rd(A_STAT, 32'h0000_0008, "R12 latched while masked");
    check_val("R10 masked irq low", 32'(irq_out), 32'h0);
    wr(A_IE1, 32'h0000_0008);
    idle(2);
    check_val("R10 set1 no effect", 32'(irq_out), 32'h0);
    wr(A_IE0, 32'h0000_0008);
    idle(1);
    check_val("R10 set0 raises irq", 32'(irq_out), 32'h1);
    wr(A_IE0, 32'h0);
    idle(1);
    check_val("R10 mask drops irq", 32'(irq_out), 32'h0);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule